// File: doc/BRIEF.md
# Directional Faulted-Pole Discriminator

This block is the decision stage of a protection relay that sits at the boundary between two protection zones of a bipolar dc line. Each valid sample carries six signed fixed-point rate-of-change estimates. Four are voltage rates, for the P and N poles on each side of the boundary inductors: the line side and the bus side. Two are current rates, one per pole. The block forms pole-difference (aerial) quantities and waits for a current rate above a trigger level. It then records peak magnitudes over a fixed window of samples.

When the window closes, the recorded peaks give three results through division-free ratio tests. The first is a direction verdict: line-side voltage rate against bus-side voltage rate. The second is the fault type, from the P-current rate against the N-current rate. The third is an in-zone trip, from the line-side voltage rate against a threshold that depends on the fault type. All thresholds and the ratio tolerance are static register inputs. The direction test can be turned off for units at a line end, where no other zone lies behind them. Once a result is produced it stays frozen until an explicit clear re-arms the unit.

Top module: `dfp_discriminator`

## Requirements
- R1: After reset, busy, done, fwd, trip are 0 and ftype is 2'b00, and the unit is armed.
- R2: While armed, a valid sample starts a window only when |ip_rate|, |in_rate| or |ip_rate − in_rate| is strictly greater than trig_thr. Any other sample leaves every output unchanged.
- R3: A window spans exactly WIN_SAMPLES valid samples, counting the trigger sample. Over those samples the unit keeps the peak magnitudes of: the line aerial rate (vlp−vln), the bus aerial rate (vbp−vbn), the P-current rate and the N-current rate. busy is high from the cycle after the trigger until done rises, and done rises in the cycle after the clock edge that accepts the last sample.
- R4: ftype encodes 2'b01 for P-to-ground, 2'b10 for N-to-ground and 2'b11 for pole-to-pole. P-to-ground is chosen when 10·Pp > (10+tol)·Pn. N-to-ground is chosen when 10·Pp < (10−tol)·Pn, with (10−tol) floored at 0. All other cases, equality included, give pole-to-pole.
- R5: fwd is 1 when dir_en is 0. Otherwise fwd is 1 only when 10·Pline > (10+tol)·Pbus.
- R6: trip is 1 only when fwd is 1 and Pline is strictly above the threshold for the fault type: thr_pp for pole-to-pole, thr_pg for either single-pole type.
- R7: While done is high, samples are ignored, and fwd, ftype, trip and done hold their values.
- R8: A cycle with clr high returns the unit to armed with all outputs 0. clr takes priority over any sample presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| clr | input | 1 | Re-arm and clear results |
| dir_en | input | 1 | Enable the direction test |
| tol_tenths | input | 4 | Ratio tolerance in tenths |
| trig_thr | input | 17 | Current-rate trigger level |
| thr_pg | input | 17 | Line voltage-rate threshold, single-pole faults |
| thr_pp | input | 17 | Line voltage-rate threshold, pole-to-pole faults |
| vlp_rate | input | 16 | P-pole line-side voltage rate (signed) |
| vln_rate | input | 16 | N-pole line-side voltage rate (signed) |
| vbp_rate | input | 16 | P-pole bus-side voltage rate (signed) |
| vbn_rate | input | 16 | N-pole bus-side voltage rate (signed) |
| ip_rate | input | 16 | P-pole current rate (signed) |
| in_rate | input | 16 | N-pole current rate (signed) |
| busy | output | 1 | Window in progress |
| done | output | 1 | Result latched |
| fwd | output | 1 | Forward-fault verdict |
| ftype | output | 2 | Fault type code |
| trip | output | 1 | In-zone trip |

## Verification
A window counter that is off by one shows at the ports as done rising one sample early or late. It also changes the verdict whenever the dropped or extra sample carries the largest rate, so the bench compares every output after every sample. A peak register that drops a sample, or keeps one from before the trigger, shows only at window end, as a wrong ftype, fwd or trip. The directed cases therefore put the defining peak at varied positions and sit exactly on the ratio boundaries. A latch or clear fault shows in the first sample after done, or in the cycle after clr.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic [1:0] {
    FT_NONE = 2'b00,
    FT_PG   = 2'b01,
    FT_NG   = 2'b10,
    FT_PP   = 2'b11
  } ftype_e;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'b00,
    ST_WINDOW = 2'b01,
    ST_HOLD   = 2'b10
  } dstate_e;

  // peak-tracked channels
  localparam int NCH     = 4;
  localparam int CH_LINE = 0;
  localparam int CH_BUS  = 1;
  localparam int CH_IP   = 2;
  localparam int CH_IN   = 3;
  // trigger-only channel (current aerial)
  localparam int CH_IA   = 4;
  localparam int NRAW    = NCH + 1;
endpackage

// File: rtl/dfp_rate_front.sv
module dfp_rate_front
  import dfp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] vlp_i,
  input  logic signed [W-1:0] vln_i,
  input  logic signed [W-1:0] vbp_i,
  input  logic signed [W-1:0] vbn_i,
  input  logic signed [W-1:0] ip_i,
  input  logic signed [W-1:0] in_i,
  input  logic [W:0]          trig_thr_i,
  output logic [W:0]          mag_o [NCH],
  output logic                trig_o
);
  localparam int MAG_W = W + 1;

  logic signed [MAG_W-1:0] raw [NRAW];
  logic        [MAG_W-1:0] mag [NRAW];

  // sign-extend by one bit so pole differences cannot overflow
  always_comb begin
    raw[CH_LINE] = $signed({vlp_i[W-1], vlp_i}) - $signed({vln_i[W-1], vln_i});
    raw[CH_BUS]  = $signed({vbp_i[W-1], vbp_i}) - $signed({vbn_i[W-1], vbn_i});
    raw[CH_IP]   = $signed({ip_i[W-1], ip_i});
    raw[CH_IN]   = $signed({in_i[W-1], in_i});
    raw[CH_IA]   = $signed({ip_i[W-1], ip_i}) - $signed({in_i[W-1], in_i});
  end

  for (genvar g = 0; g < NRAW; g++) begin : g_abs
    assign mag[g] = raw[g][MAG_W-1] ? MAG_W'(-raw[g]) : MAG_W'(raw[g]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign mag_o[g] = mag[g];
  end

  assign trig_o = (mag[CH_IP] > trig_thr_i) ||
                  (mag[CH_IN] > trig_thr_i) ||
                  (mag[CH_IA] > trig_thr_i);
endmodule

// File: rtl/dfp_peak_hold.sv
module dfp_peak_hold
  import dfp_pkg::*;
#(
  parameter int MAG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             upd_i,
  input  logic             clr_i,
  input  logic [MAG_W-1:0] mag_i    [NCH],
  output logic [MAG_W-1:0] pk_nx_o  [NCH]
);
  logic [MAG_W-1:0] pk    [NCH];
  logic [MAG_W-1:0] pk_nx [NCH];
  logic             en;

  assign en = clr_i | load_i | upd_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      if (clr_i)                         pk_nx[g] = '0;
      else if (load_i)                   pk_nx[g] = mag_i[g];
      else if (upd_i && mag_i[g] > pk[g]) pk_nx[g] = mag_i[g];
      else                               pk_nx[g] = pk[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pk[g] <= '0;
      else if (en) pk[g] <= pk_nx[g];
    end

    assign pk_nx_o[g] = pk_nx[g];

    // R3: every sample inside the window is covered by the held peak
    a_r3_peak_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !load_i && !clr_i) |=> (pk[g] >= $past(mag_i[g])));

    // R3: a load discards anything held from before the trigger
    a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i) |=> (pk[g] == $past(mag_i[g])));
  end
endmodule

// File: rtl/dfp_classify.sv
module dfp_classify
  import dfp_pkg::*;
#(
  parameter int MAG_W = 17,
  parameter int TOL_W = 4
) (
  input  logic [MAG_W-1:0] pk_line_i,
  input  logic [MAG_W-1:0] pk_bus_i,
  input  logic [MAG_W-1:0] pk_p_i,
  input  logic [MAG_W-1:0] pk_n_i,
  input  logic [TOL_W-1:0] tol_i,
  input  logic             dir_en_i,
  input  logic [MAG_W-1:0] thr_pg_i,
  input  logic [MAG_W-1:0] thr_pp_i,
  output logic             fwd_o,
  output ftype_e           ftype_o,
  output logic             trip_o
);
  localparam int MULT_W = TOL_W + 5;
  localparam int PROD_W = MAG_W + MULT_W;

  logic [MULT_W-1:0] k_hi, k_lo;
  logic [PROD_W-1:0] line10, bus_hi, p10, n_hi, n_lo;
  logic [MAG_W-1:0]  thr_sel;

  always_comb begin
    k_hi = MULT_W'(10) + MULT_W'(tol_i);
    k_lo = (MULT_W'(tol_i) >= MULT_W'(10)) ? '0 : (MULT_W'(10) - MULT_W'(tol_i));

    line10 = PROD_W'(pk_line_i) * PROD_W'(10);
    bus_hi = PROD_W'(pk_bus_i)  * PROD_W'(k_hi);
    p10    = PROD_W'(pk_p_i)    * PROD_W'(10);
    n_hi   = PROD_W'(pk_n_i)    * PROD_W'(k_hi);
    n_lo   = PROD_W'(pk_n_i)    * PROD_W'(k_lo);

    fwd_o = !dir_en_i || (line10 > bus_hi);

    if (p10 > n_hi)      ftype_o = FT_PG;
    else if (p10 < n_lo) ftype_o = FT_NG;
    else                 ftype_o = FT_PP;

    thr_sel = (ftype_o == FT_PP) ? thr_pp_i : thr_pg_i;
    trip_o  = fwd_o && (pk_line_i > thr_sel);
  end
endmodule

// File: rtl/dfp_discriminator.sv
module dfp_discriminator
  import dfp_pkg::*;
#(
  parameter int W           = 16,
  parameter int WIN_SAMPLES = 10,
  parameter int TOL_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                clr,
  input  logic                dir_en,
  input  logic [TOL_W-1:0]    tol_tenths,
  input  logic [W:0]          trig_thr,
  input  logic [W:0]          thr_pg,
  input  logic [W:0]          thr_pp,
  input  logic signed [W-1:0] vlp_rate,
  input  logic signed [W-1:0] vln_rate,
  input  logic signed [W-1:0] vbp_rate,
  input  logic signed [W-1:0] vbn_rate,
  input  logic signed [W-1:0] ip_rate,
  input  logic signed [W-1:0] in_rate,
  output logic                busy,
  output logic                done,
  output logic                fwd,
  output logic [1:0]          ftype,
  output logic                trip
);
  localparam int MAG_W = W + 1;
  localparam int CNT_W = $clog2(WIN_SAMPLES + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // front end
  logic [MAG_W-1:0] mag   [NCH];
  logic [MAG_W-1:0] pk_nx [NCH];
  logic             trig;

  dfp_rate_front #(.W(W)) u_front (
    .vlp_i      (vlp_rate),
    .vln_i      (vln_rate),
    .vbp_i      (vbp_rate),
    .vbn_i      (vbn_rate),
    .ip_i       (ip_rate),
    .in_i       (in_rate),
    .trig_thr_i (trig_thr),
    .mag_o      (mag),
    .trig_o     (trig)
  );

  // sequencing
  dstate_e    st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, cnt_inc;
  logic       start, upd, last, st_en;

  always_comb begin
    start   = (st == ST_ARMED)  && smp_valid && trig && !clr;
    upd     = (st == ST_WINDOW) && smp_valid && !clr;
    cnt_inc = start ? CNT_W'(1) : (cnt + CNT_W'(1));
    last    = (start || upd) && (cnt_inc == CNT_W'(WIN_SAMPLES));

    st_nx  = st;
    cnt_nx = cnt;
    if (clr) begin
      st_nx  = ST_ARMED;
      cnt_nx = '0;
    end else if (start || upd) begin
      cnt_nx = cnt_inc;
      st_nx  = last ? ST_HOLD : ST_WINDOW;
    end
    st_en = clr || start || upd;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st  <= ST_ARMED;
      cnt <= '0;
    end else if (st_en) begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  dfp_peak_hold #(.MAG_W(MAG_W)) u_peaks (
    .clk     (clk),
    .rst_n   (rst_q),
    .load_i  (start),
    .upd_i   (upd),
    .clr_i   (clr),
    .mag_i   (mag),
    .pk_nx_o (pk_nx)
  );

  logic   cls_fwd, cls_trip;
  ftype_e cls_type;

  dfp_classify #(.MAG_W(MAG_W), .TOL_W(TOL_W)) u_cls (
    .pk_line_i (pk_nx[CH_LINE]),
    .pk_bus_i  (pk_nx[CH_BUS]),
    .pk_p_i    (pk_nx[CH_IP]),
    .pk_n_i    (pk_nx[CH_IN]),
    .tol_i     (tol_tenths),
    .dir_en_i  (dir_en),
    .thr_pg_i  (thr_pg),
    .thr_pp_i  (thr_pp),
    .fwd_o     (cls_fwd),
    .ftype_o   (cls_type),
    .trip_o    (cls_trip)
  );

  // result registers
  logic       res_fwd_nx, res_trip_nx, res_en;
  logic [1:0] res_type_nx;

  always_comb begin
    res_en      = clr || last;
    res_fwd_nx  = clr ? 1'b0  : cls_fwd;
    res_trip_nx = clr ? 1'b0  : cls_trip;
    res_type_nx = clr ? 2'b00 : cls_type;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fwd   <= 1'b0;
      trip  <= 1'b0;
      ftype <= 2'b00;
    end else if (res_en) begin
      fwd   <= res_fwd_nx;
      trip  <= res_trip_nx;
      ftype <= res_type_nx;
    end
  end

  assign busy = (st == ST_WINDOW);
  assign done = (st == ST_HOLD);

  // R1/R4: a result exists exactly when a fault type is reported
  a_r4_type_with_done: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> (ftype != 2'b00));
  a_r1_idle_no_type: assert property (@(posedge clk) disable iff (!rst_q)
    !done |-> (ftype == 2'b00 && !trip && !fwd));

  // R6: trip only on a forward verdict
  a_r6_trip_forward: assert property (@(posedge clk) disable iff (!rst_q)
    trip |-> fwd);

  // R2: a non-triggering sample keeps the unit armed
  a_r2_no_false_start: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_ARMED && smp_valid && !trig) |=> (st == ST_ARMED));

  // R3: window count stays inside its bound
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> (cnt != '0 && cnt < CNT_W'(WIN_SAMPLES)));

  // R7: results frozen while held
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_q)
    (done && !clr) |=> (done && $stable(fwd) && $stable(ftype) && $stable(trip)));

  // R8: clear wins
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_q)
    clr |=> (!busy && !done && ftype == 2'b00));
endmodule

// File: tb/tb_dfp_discriminator.sv
module tb_dfp_discriminator;
  localparam int W   = 16;
  localparam int WIN = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, smp_valid, clr, dir_en;
  logic [3:0] tol_tenths;
  logic [W:0] trig_thr, thr_pg, thr_pp;
  logic signed [W-1:0] vlp_rate, vln_rate, vbp_rate, vbn_rate, ip_rate, in_rate;
  logic busy, done, fwd, trip;
  logic [1:0] ftype;

  dfp_discriminator dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .clr(clr), .dir_en(dir_en),
    .tol_tenths(tol_tenths), .trig_thr(trig_thr), .thr_pg(thr_pg), .thr_pp(thr_pp),
    .vlp_rate(vlp_rate), .vln_rate(vln_rate), .vbp_rate(vbp_rate), .vbn_rate(vbn_rate),
    .ip_rate(ip_rate), .in_rate(in_rate),
    .busy(busy), .done(done), .fwd(fwd), .ftype(ftype), .trip(trip)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_busy, m_done, m_fwd, m_trip;
  int m_type, m_cnt;
  int pk_l, pk_b, pk_p, pk_n;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_done = 0; m_fwd = 0; m_trip = 0; m_type = 0; m_cnt = 0;
    pk_l = 0; pk_b = 0; pk_p = 0; pk_n = 0;
  endtask

  task automatic model_decide();
    int t = int'(tol_tenths);
    int lo = (10 - t < 0) ? 0 : 10 - t;
    int thr;
    m_fwd = !dir_en || (pk_l * 10 > pk_b * (10 + t));
    if (pk_p * 10 > pk_n * (10 + t))  m_type = 1;
    else if (pk_p * 10 < pk_n * lo)   m_type = 2;
    else                              m_type = 3;
    thr = (m_type == 3) ? int'(thr_pp) : int'(thr_pg);
    m_trip = m_fwd && (pk_l > thr);
    m_busy = 0; m_done = 1;
  endtask

  task automatic model_sample(int a, int b, int c, int d, int e, int f);
    int l = iabs(a - b), bb = iabs(c - d), p = iabs(e), n = iabs(f);
    int tt = int'(trig_thr);
    if (!m_busy && !m_done) begin
      if (p > tt || n > tt || iabs(e - f) > tt) begin
        m_busy = 1; m_cnt = 1; pk_l = l; pk_b = bb; pk_p = p; pk_n = n;
        if (m_cnt == WIN) model_decide();
      end
    end else if (m_busy) begin
      if (l > pk_l) pk_l = l;
      if (bb > pk_b) pk_b = bb;
      if (p > pk_p) pk_p = p;
      if (n > pk_n) pk_n = n;
      m_cnt++;
      if (m_cnt == WIN) model_decide();
    end
  endtask

  task automatic compare(string tag);
    logic [5:0] act, exp;
    act = {busy, done, fwd, ftype, trip};
    exp = {m_busy, m_done, m_fwd, 2'(m_type), m_trip};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s busy/done/fwd/type/trip actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(int a, int b, int c, int d, int e, int f, bit cl, string tag);
    @(negedge clk);
    vlp_rate = 16'(a); vln_rate = 16'(b); vbp_rate = 16'(c); vbn_rate = 16'(d);
    ip_rate = 16'(e); in_rate = 16'(f);
    smp_valid = 1'b1; clr = cl;
    @(negedge clk);
    smp_valid = 1'b0; clr = 1'b0;
    if (cl) model_reset();
    else    model_sample(a, b, c, d, e, f);
    compare(tag);
  endtask

  task automatic do_clear(string tag);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_reset();
    compare(tag);
  endtask

  task automatic run_const(int a, int b, int c, int d, int e, int f, string tag);
    for (int i = 0; i < WIN; i++) send(a, b, c, d, e, f, 1'b0, tag);
  endtask

  function automatic int rnd(int span);
    return int'($urandom_range(2 * span)) - span;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; smp_valid = 0; clr = 0; dir_en = 1; tol_tenths = 4'd1;
    trig_thr = 17'd2000; thr_pg = 17'd3000; thr_pp = 17'd6000;
    vlp_rate = '0; vln_rate = '0; vbp_rate = '0; vbn_rate = '0; ip_rate = '0; in_rate = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1 reset");

    // R2: sub-threshold samples, equal-to-threshold too
    send(9000, 0, 0, 0, 1999, -1, 1'b0, "R2 below");
    send(0, 0, 0, 0, 2000, 0, 1'b0, "R2 equal");
    // R2: only the current difference exceeds the level
    send(4000, 0, 100, 0, 1500, -1500, 1'b0, "R2 aerial trigger");
    for (int i = 1; i < WIN; i++) send(4000, 0, 100, 0, 1500, -1500, 1'b0, "R3 window");
    // R7: held result ignores a big sample
    send(30000, -30000, 0, 0, 30000, 0, 1'b0, "R7 hold");
    send(0, 0, 0, 0, 0, 9000, 1'b0, "R7 hold");
    do_clear("R8 clear");

    // R4/R6 single-pole P, in zone
    run_const(4000, 0, 100, 0, 3000, 1000, "R4 P-ground");
    do_clear("R8 clear");
    run_const(4000, 0, 100, 0, 500, 3000, "R4 N-ground");
    do_clear("R8 clear");
    // R4 boundary: 10*P == 11*N gives pole-to-pole; R6 uses pp level
    run_const(4000, 0, 100, 0, 2200, 2000, "R4 PP upper edge / R6 no trip");
    do_clear("R8 clear");
    run_const(3500, -3500, 100, 0, 2700, 3000, "R4 PP lower edge / R6 trip");
    do_clear("R8 clear");
    // R5 reverse vs disabled direction
    run_const(4000, 0, 5000, 0, 3000, 1000, "R5 reverse");
    do_clear("R8 clear");
    dir_en = 0;
    run_const(4000, 0, 5000, 0, 3000, 1000, "R5 direction off");
    do_clear("R8 clear");
    dir_en = 1;
    // R5 edge: 10*L == 11*B is reverse
    run_const(4400, 0, 4000, 0, 3000, 1000, "R5 ratio edge");
    do_clear("R8 clear");

    // R3: peak arrives on the last sample of the window
    send(0, 0, 0, 0, 3000, 0, 1'b0, "R3 trigger");
    for (int i = 2; i < WIN; i++) send(100, 0, 50, 0, 100, 100, 1'b0, "R3 window");
    send(5000, 0, 100, 0, 100, 100, 1'b0, "R3 last sample peak");
    do_clear("R8 clear");

    // R8: trigger sample presented with clr is dropped
    send(4000, 0, 0, 0, 9000, 0, 1'b1, "R8 priority");
    // R8: clear during a window
    send(4000, 0, 0, 0, 9000, 0, 1'b0, "R2 trigger");
    send(4000, 0, 0, 0, 9000, 0, 1'b0, "R3 window");
    do_clear("R8 mid-window");

    // constrained random events
    for (int ev = 0; ev < 40; ev++) begin
      int pre = int'($urandom_range(3));
      dir_en = 1'($urandom_range(1));
      tol_tenths = 4'($urandom_range(3));
      for (int k = 0; k < pre; k++)
        send(rnd(8000), rnd(8000), rnd(8000), rnd(8000), rnd(900), rnd(900), 1'b0, "R2 random quiet");
      send(rnd(8000), rnd(8000), rnd(8000), rnd(8000), 2500 + rnd(400), rnd(4000), 1'b0, "R2 random trigger");
      for (int k = 1; k < WIN + 2; k++)
        send(rnd(8000), rnd(8000), rnd(8000), rnd(8000), rnd(6000), rnd(6000), 1'b0,
             "R3/R4/R5/R6/R7 random");
      do_clear("R8 random clear");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule